// File: doc/BRIEF.md
# Buffer-to-Memory Copy Engine

This block moves blocks of 32-bit words between a 512-word internal buffer and an external synchronous memory bank. A host reaches it through a simple word-addressed register bus. The host loads or reads the buffer through a window of consecutive register offsets. It programs two setup words: one holds the buffer start index and the memory start address, the other holds the direction and the word count. A write to a trigger register then launches the copy, and the host polls a status word until its done bit is set.

A select register decides who drives the memory port. When it is set, the engine owns the port. When it is clear, an application-side request path passes straight through to the memory. While the application owns the port, the engine holds its position and resumes when the port is returned. A soft reset register aborts a running copy and clears the status.

Top module: `copy_engine`

## Requirements
- R1: After rst_n is released, the status word at offset 0x000 reads 0, the select word at offset 0x900 reads 0, and mem_req is low while the application inputs are idle.
- R2: A host write to offset 0x100+i (i from 0 to 511) stores the word in buffer entry i. A host read of that offset returns the stored word on hrdata in the cycle after hrd_en is high. This also holds while a copy is running.
- R3: A write to offset 0x000 sets the buffer start index from bits 31..23 and the memory start word address from bits 22..0.
- R4: A write to offset 0x001 sets the word count from bits 7..0, where 0 means 256. Bit 20 low selects the buffer-to-memory direction. Words go to consecutive memory addresses from consecutive buffer entries, and no address outside the range is written.
- R5: With bit 20 of offset 0x001 high, words are read from memory, starting at the start address, and written into consecutive buffer entries. The host can then read them back through the window.
- R6: Any write to offset 0x003 starts a copy, whatever the data. The done bit (bit 0 of offset 0x000) clears when a copy starts and reads 1 once the last word has been transferred.
- R7: A write to offset 0x003 while a copy is running is ignored. The running copy completes with its original setup, and no second copy follows.
- R8: The buffer index wraps modulo 512, so a copy that passes entry 511 continues at entry 0.
- R9: When bit 0 of offset 0x900 is 1, the engine drives the memory port. When it is 0, app_req, app_we, app_addr and app_wdata drive the memory port, and the engine issues no memory cycle and makes no progress until the bit returns to 1.
- R10: Writing a word with bit 0 set to offset 0x800 aborts any running copy and clears the done bit. Memory words not yet reached stay untouched, and a later trigger starts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hwr_en | input | 1 | Host register write strobe |
| hrd_en | input | 1 | Host register read strobe |
| haddr | input | 12 | Host word offset |
| hwdata | input | 32 | Host write data |
| hrdata | output | 32 | Host read data, valid the cycle after hrd_en |
| app_req | input | 1 | Application memory request |
| app_we | input | 1 | Application write enable |
| app_addr | input | 23 | Application memory word address |
| app_wdata | input | 32 | Application write data |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 23 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read request |

## Verification
Two things can touch the buffer in the same cycle: a host window access and a step of the copy engine. Host writes and reads go through one port of the buffer and the engine uses the other, so the two never block each other. The bench provokes this by reading back a buffer entry through the window while a buffer-to-memory copy of that same region is running. It also sends a second trigger, with new setup words, during that copy. It then judges both that the host read returns the value it wrote earlier and that the memory image afterwards matches only the first setup.

// File: rtl/cpe_pkg.sv
// Package: shared constants, register offsets and types for the copy engine.
// Assumes a 12-bit host word offset space and a 23-bit memory word address.
package cpe_pkg;
    localparam int DW        = 32;
    localparam int HA_W      = 12;
    localparam int BUF_AW    = 9;
    localparam int BUF_DEPTH = 1 << BUF_AW;
    localparam int MEM_AW    = 23;
    localparam int CNT_W     = 8;
    localparam int LEFT_W    = CNT_W + 1;
    localparam int DIR_BIT   = 20;

    localparam logic [HA_W-1:0] A_SETUP0  = 12'h000;
    localparam logic [HA_W-1:0] A_SETUP1  = 12'h001;
    localparam logic [HA_W-1:0] A_GO      = 12'h003;
    localparam logic [HA_W-1:0] A_WIN     = 12'h100;
    localparam logic [HA_W-1:0] A_WIN_END = A_WIN + HA_W'(BUF_DEPTH);
    localparam logic [HA_W-1:0] A_SRST    = 12'h800;
    localparam logic [HA_W-1:0] A_OWNER   = 12'h900;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_PUSH, S_ISSUE, S_CAPT
    } eng_state_t;

    typedef struct packed {
        logic [BUF_AW-1:0] off;
        logic [MEM_AW-1:0] addr;
        logic              rd_dir;
        logic [CNT_W-1:0]  cnt;
    } xfer_cfg_t;
endpackage

// File: rtl/cpe_regs.sv
// Module: host register decode for the copy engine.
// Holds the two setup words and the port-owner bit, produces the trigger
// and soft-reset pulses, steers window accesses to the buffer host port,
// and returns read data one cycle after the read strobe.
// Assumes the host never asserts write and read in the same cycle.
module cpe_regs
    import cpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hwr_en,
    input  logic              hrd_en,
    input  logic [HA_W-1:0]   haddr,
    input  logic [DW-1:0]     hwdata,
    output logic [DW-1:0]     hrdata,
    input  logic              done,
    output xfer_cfg_t         cfg,
    output logic              trig,
    output logic              soft_rst,
    output logic              host_sel,
    output logic              win_en,
    output logic              win_we,
    output logic [BUF_AW-1:0] win_idx,
    output logic [DW-1:0]     win_wdata,
    input  logic [DW-1:0]     win_rdata
);
    logic          win_hit;
    logic          rd_win_q;
    logic [DW-1:0] rd_reg_q;

    // Window decode and host-side buffer port.
    always_comb begin
        win_hit   = (haddr >= A_WIN) && (haddr < A_WIN_END);
        win_en    = win_hit && (hwr_en || hrd_en);
        win_we    = hwr_en;
        win_idx   = BUF_AW'(haddr - A_WIN);
        win_wdata = hwdata;
        trig      = hwr_en && (haddr == A_GO);
        soft_rst  = hwr_en && (haddr == A_SRST) && hwdata[0];
    end

    // Setup words and owner bit capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            host_sel <= 1'b0;
        end else if (hwr_en) begin
            if (haddr == A_SETUP0) begin
                cfg.off  <= hwdata[DW-1:MEM_AW];
                cfg.addr <= hwdata[MEM_AW-1:0];
            end
            if (haddr == A_SETUP1) begin
                cfg.rd_dir <= hwdata[DIR_BIT];
                cfg.cnt    <= hwdata[CNT_W-1:0];
            end
            if (haddr == A_OWNER)
                host_sel <= hwdata[0];
        end
    end

    // Registered read path for status and owner words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_win_q <= 1'b0;
            rd_reg_q <= '0;
        end else if (hrd_en) begin
            rd_win_q <= win_hit;
            if (haddr == A_SETUP0)
                rd_reg_q <= {{(DW-1){1'b0}}, done};
            else if (haddr == A_OWNER)
                rd_reg_q <= {{(DW-1){1'b0}}, host_sel};
            else
                rd_reg_q <= '0;
        end
    end

    // Read data select.
    always_comb hrdata = rd_win_q ? win_rdata : rd_reg_q;
endmodule

// File: rtl/cpe_buffer.sv
// Module: two-port synchronous buffer RAM.
// Port A serves the host window, port B the copy engine. Reads return data
// on the next cycle; if both ports write one entry in a cycle, port B wins.
module cpe_buffer
    import cpe_pkg::*;
(
    input  logic              clk,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [BUF_AW-1:0] a_idx,
    input  logic [DW-1:0]     a_wdata,
    output logic [DW-1:0]     a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [BUF_AW-1:0] b_idx,
    input  logic [DW-1:0]     b_wdata,
    output logic [DW-1:0]     b_rdata
);
    logic [DW-1:0] store [BUF_DEPTH];

    // Both ports, one process so the array has a single driver.
    always_ff @(posedge clk) begin
        if (a_en && a_we)  store[a_idx] <= a_wdata;
        if (b_en && b_we)  store[b_idx] <= b_wdata;
        if (a_en && !a_we) a_rdata <= store[a_idx];
        if (b_en && !b_we) b_rdata <= store[b_idx];
    end
endmodule

// File: rtl/cpe_copy_fsm.sv
// Module: copy sequencer.
// Moves one word every two cycles between buffer and memory in ascending
// order. Stalls in its memory-cycle states while it does not own the port.
// Assumes memory read data arrives exactly one cycle after the request.
module cpe_copy_fsm
    import cpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  xfer_cfg_t         cfg,
    input  logic              trig,
    input  logic              soft_rst,
    input  logic              host_sel,
    output logic              bb_en,
    output logic              bb_we,
    output logic [BUF_AW-1:0] bb_idx,
    output logic [DW-1:0]     bb_wdata,
    input  logic [DW-1:0]     bb_rdata,
    output logic              eng_req,
    output logic              eng_we,
    output logic [MEM_AW-1:0] eng_addr,
    output logic [DW-1:0]     eng_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic              done
);
    eng_state_t        state_q;
    logic [BUF_AW-1:0] idx_q;
    logic [MEM_AW-1:0] addr_q;
    logic [LEFT_W-1:0] left_q;
    logic              dir_q;
    logic              done_q;
    logic              last;

    always_comb last = (left_q == LEFT_W'(1));

    // Sequencer state, pointers and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            addr_q  <= '0;
            left_q  <= '0;
            dir_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (trig) begin
                    idx_q   <= cfg.off;
                    addr_q  <= cfg.addr;
                    left_q  <= (cfg.cnt == '0) ? LEFT_W'(1 << CNT_W) : {1'b0, cfg.cnt};
                    dir_q   <= cfg.rd_dir;
                    done_q  <= 1'b0;
                    state_q <= cfg.rd_dir ? S_ISSUE : S_FETCH;
                end
                S_FETCH: state_q <= S_PUSH;
                S_PUSH: if (host_sel) begin
                    idx_q   <= idx_q + 1'b1;
                    addr_q  <= addr_q + 1'b1;
                    left_q  <= left_q - 1'b1;
                    done_q  <= last;
                    state_q <= last ? S_IDLE : S_FETCH;
                end
                S_ISSUE: if (host_sel) state_q <= S_CAPT;
                S_CAPT: begin
                    idx_q   <= idx_q + 1'b1;
                    addr_q  <= addr_q + 1'b1;
                    left_q  <= left_q - 1'b1;
                    done_q  <= last;
                    state_q <= last ? S_IDLE : S_ISSUE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Buffer and memory side drive from the current state.
    always_comb begin
        bb_en     = (state_q == S_FETCH) || (state_q == S_CAPT);
        bb_we     = (state_q == S_CAPT);
        bb_idx    = idx_q;
        bb_wdata  = mem_rdata;
        eng_req   = host_sel && ((state_q == S_PUSH) || (state_q == S_ISSUE));
        eng_we    = (state_q == S_PUSH);
        eng_addr  = addr_q;
        eng_wdata = bb_rdata;
        done      = done_q;
    end

    p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_sel && state_q == S_PUSH && !soft_rst) |=> (state_q == S_PUSH && $stable(left_q)));
    p_start_clears_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && state_q == S_IDLE && !soft_rst) |=> (!done_q && state_q != S_IDLE));
    p_busy_trig_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && state_q != S_IDLE && !soft_rst) |=> $stable(dir_q));
    p_soft_reset_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (state_q == S_IDLE && !done_q));
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |-> (left_q != '0 && left_q <= LEFT_W'(1 << CNT_W)));
endmodule

// File: rtl/copy_engine.sv
// Module: top of the buffer-to-memory copy engine.
// Connects register decode, buffer RAM and sequencer, and selects whether
// the sequencer or the application request path drives the memory port.
// Assumes a synchronous single-cycle memory behind the mem_* pins.
module copy_engine
    import cpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hwr_en,
    input  logic              hrd_en,
    input  logic [HA_W-1:0]   haddr,
    input  logic [DW-1:0]     hwdata,
    output logic [DW-1:0]     hrdata,
    input  logic              app_req,
    input  logic              app_we,
    input  logic [MEM_AW-1:0] app_addr,
    input  logic [DW-1:0]     app_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata
);
    xfer_cfg_t         cfg;
    logic              trig, soft_rst, host_sel, done;
    logic              win_en, win_we;
    logic [BUF_AW-1:0] win_idx;
    logic [DW-1:0]     win_wdata, win_rdata;
    logic              bb_en, bb_we;
    logic [BUF_AW-1:0] bb_idx;
    logic [DW-1:0]     bb_wdata, bb_rdata;
    logic              eng_req, eng_we;
    logic [MEM_AW-1:0] eng_addr;
    logic [DW-1:0]     eng_wdata;

    cpe_regs u_regs (
        .clk(clk), .rst_n(rst_n), .hwr_en(hwr_en), .hrd_en(hrd_en),
        .haddr(haddr), .hwdata(hwdata), .hrdata(hrdata), .done(done),
        .cfg(cfg), .trig(trig), .soft_rst(soft_rst), .host_sel(host_sel),
        .win_en(win_en), .win_we(win_we), .win_idx(win_idx),
        .win_wdata(win_wdata), .win_rdata(win_rdata)
    );

    cpe_buffer u_buf (
        .clk(clk),
        .a_en(win_en), .a_we(win_we), .a_idx(win_idx), .a_wdata(win_wdata), .a_rdata(win_rdata),
        .b_en(bb_en), .b_we(bb_we), .b_idx(bb_idx), .b_wdata(bb_wdata), .b_rdata(bb_rdata)
    );

    cpe_copy_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .trig(trig), .soft_rst(soft_rst),
        .host_sel(host_sel), .bb_en(bb_en), .bb_we(bb_we), .bb_idx(bb_idx),
        .bb_wdata(bb_wdata), .bb_rdata(bb_rdata), .eng_req(eng_req),
        .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
        .mem_rdata(mem_rdata), .done(done)
    );

    // Memory port owner select.
    always_comb begin
        if (host_sel) begin
            mem_req   = eng_req;
            mem_we    = eng_we;
            mem_addr  = eng_addr;
            mem_wdata = eng_wdata;
        end else begin
            mem_req   = app_req;
            mem_we    = app_we;
            mem_addr  = app_addr;
            mem_wdata = app_wdata;
        end
    end
endmodule

// File: tb/tb_copy_engine.sv
module tb_copy_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hwr_en = 1'b0, hrd_en = 1'b0;
    logic [11:0] haddr = '0;
    logic [31:0] hwdata = '0;
    logic [31:0] hrdata;
    logic        app_req = 1'b0, app_we = 1'b0;
    logic [22:0] app_addr = '0;
    logic [31:0] app_wdata = '0;
    logic        mem_req, mem_we;
    logic [22:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] tb_mem  [0:1023];
    logic [31:0] expmem  [0:1023];
    logic [31:0] bmodel  [0:511];
    int nvec = 0, nfail = 0;
    bit finished = 1'b0;

    copy_engine dut (
        .clk(clk), .rst_n(rst_n), .hwr_en(hwr_en), .hrd_en(hrd_en),
        .haddr(haddr), .hwdata(hwdata), .hrdata(hrdata),
        .app_req(app_req), .app_we(app_we), .app_addr(app_addr), .app_wdata(app_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Synchronous single-cycle memory model.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) tb_mem[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= tb_mem[mem_addr[9:0]];
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); hwr_en = 1'b1; haddr = a; hwdata = d;
        @(negedge clk); hwr_en = 1'b0;
    endtask

    task automatic hread(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); hrd_en = 1'b1; haddr = a;
        @(negedge clk); hrd_en = 1'b0; d = hrdata;
    endtask

    task automatic app_write(input int a, input logic [31:0] d);
        @(negedge clk); app_req = 1'b1; app_we = 1'b1; app_addr = 23'(a); app_wdata = d;
        @(negedge clk); app_req = 1'b0; app_we = 1'b0;
        expmem[a % 1024] = d;
    endtask

    task automatic set_owner(input bit v);
        hwrite(12'h900, {31'b0, v});
    endtask

    task automatic program_xfer(input int off, input int addr, input int cnt, input bit rd, input logic [31:0] go);
        hwrite(12'h000, {9'(off), 23'(addr)});
        hwrite(12'h001, {11'b0, rd, 12'b0, 8'(cnt)});
        hwrite(12'h003, go);
    endtask

    task automatic wait_done(input string req);
        logic [31:0] s;
        bit ok = 1'b0;
        for (int k = 0; k < 3000 && !ok; k++) begin
            hread(12'h000, s);
            if (s[0]) ok = 1'b1;
        end
        check(ok, req, {31'b0, ok}, 32'h1);
    endtask

    // Expected effect of a completed copy on the bench models.
    task automatic apply_expect(input int off, input int addr, input int cnt, input bit rd);
        int n = (cnt == 0) ? 256 : cnt;
        for (int i = 0; i < n; i++) begin
            if (!rd) expmem[(addr + i) % 1024] = bmodel[(off + i) % 512];
            else     bmodel[(off + i) % 512]   = expmem[(addr + i) % 1024];
        end
    endtask

    function automatic int mem_mismatch();
        int m = 0;
        for (int i = 0; i < 1024; i++) if (tb_mem[i] !== expmem[i]) m++;
        return m;
    endfunction

    task automatic check_buf(input int lo, input int n, input string req);
        logic [31:0] d;
        int m = 0;
        for (int i = 0; i < n; i++) begin
            hread(12'(12'h100 + ((lo + i) % 512)), d);
            if (d !== bmodel[(lo + i) % 512]) m++;
        end
        check(m == 0, req, m, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec + 1, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, pat;
        void'($urandom(32'd20241));
        for (int i = 0; i < 1024; i++) begin tb_mem[i] = 32'(i * 7); expmem[i] = 32'(i * 7); end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        hread(12'h000, d); check(d == 0, "R1 status", d, 0);
        hread(12'h900, d); check(d == 0, "R1 owner", d, 0);
        check(mem_req == 1'b0, "R1 mem_req", {31'b0, mem_req}, 0);

        // Fill buffer with random words and read some back
        for (int i = 0; i < 512; i++) begin
            bmodel[i] = $urandom;
            hwrite(12'(12'h100 + i), bmodel[i]);
        end
        check_buf(0, 8, "R2 window low");
        check_buf(505, 7, "R2 window top");

        // Write direction, busy re-trigger ignored, host read during copy
        set_owner(1'b1);
        hread(12'h900, d); check(d == 1, "R9 owner readback", d, 1);
        program_xfer(5, 12'h040, 20, 1'b0, 32'hDEADBEEF);
        program_xfer(0, 12'h380, 3, 1'b0, 32'h0);
        hread(12'h105, d); check(d == bmodel[5], "R2 window during copy", d, bmodel[5]);
        wait_done("R6 done after write copy");
        apply_expect(5, 12'h040, 20, 1'b0);
        check(mem_mismatch() == 0, "R4 R3 R7 memory image", mem_mismatch(), 0);
        hread(12'h000, d); check(d[0] == 1'b1, "R6 done stays set", d, 1);

        // Done clears at a new trigger (setup still holds the second config)
        hwrite(12'h003, 32'h0);
        hread(12'h000, d); check(d[0] == 1'b0, "R6 done cleared on trigger", d, 0);
        wait_done("R6 done second");
        apply_expect(0, 12'h380, 3, 1'b0);
        check(mem_mismatch() == 0, "R3 second setup image", mem_mismatch(), 0);

        // Count 0 means 256, with buffer wrap
        program_xfer(400, 12'h100, 0, 1'b0, 32'h5);
        wait_done("R4 done count zero");
        apply_expect(400, 12'h100, 0, 1'b0);
        check(mem_mismatch() == 0, "R4 R8 count zero wrap", mem_mismatch(), 0);

        // Read direction, preload through the application path
        set_owner(1'b0);
        for (int i = 0; i < 20; i++) app_write(12'h200 + i, $urandom);
        for (int i = 0; i < 4; i++) app_write(12'h250 + i, $urandom);
        check(tb_mem[12'h200] == expmem[12'h200], "R9 app path write", tb_mem[12'h200], expmem[12'h200]);
        set_owner(1'b1);
        program_xfer(300, 12'h200, 16, 1'b1, 32'h0);
        wait_done("R5 done read copy");
        apply_expect(300, 12'h200, 16, 1'b1);
        check_buf(298, 20, "R5 read into buffer");
        program_xfer(510, 12'h250, 4, 1'b1, 32'h0);
        wait_done("R8 done read wrap");
        apply_expect(510, 12'h250, 4, 1'b1);
        check_buf(508, 8, "R8 read wrap");

        // Stall while the application owns the port
        program_xfer(0, 12'h300, 10, 1'b0, 32'h0);
        set_owner(1'b0);
        pat = $urandom;
        app_write(12'h3F0, pat);
        repeat (60) @(negedge clk);
        hread(12'h000, d); check(d[0] == 1'b0, "R9 stalled not done", d, 0);
        check(tb_mem[12'h3F0] == pat, "R9 app write passes", tb_mem[12'h3F0], pat);
        set_owner(1'b1);
        wait_done("R9 done after resume");
        apply_expect(0, 12'h300, 10, 1'b0);
        check(mem_mismatch() == 0, "R9 image after stall", mem_mismatch(), 0);

        // Soft reset aborts
        set_owner(1'b0);
        app_write(199, ~bmodel[199]);
        set_owner(1'b1);
        program_xfer(0, 0, 200, 1'b0, 32'h0);
        repeat (10) @(negedge clk);
        hwrite(12'h800, 32'h1);
        hread(12'h000, d); check(d[0] == 1'b0, "R10 status cleared", d, 0);
        repeat (500) @(negedge clk);
        check(tb_mem[199] == ~bmodel[199], "R10 tail untouched", tb_mem[199], ~bmodel[199]);
        for (int i = 0; i < 1024; i++) expmem[i] = tb_mem[i];
        program_xfer(50, 12'h3A0, 6, 1'b0, 32'h0);
        wait_done("R10 restart done");
        apply_expect(50, 12'h3A0, 6, 1'b0);
        check(mem_mismatch() == 0, "R10 restart image", mem_mismatch(), 0);

        // Random transfers
        for (int t = 0; t < 8; t++) begin
            int off = $urandom % 512;
            int addr = $urandom % 512;
            int cnt = $urandom % 256;
            bit rd = 1'($urandom);
            int n = (cnt == 0) ? 256 : cnt;
            if (rd) begin
                set_owner(1'b0);
                for (int i = 0; i < n; i++) app_write(addr + i, $urandom);
                set_owner(1'b1);
            end
            program_xfer(off, addr, cnt, rd, $urandom);
            wait_done("R6 random done");
            apply_expect(off, addr, cnt, rd);
            if (rd) check_buf(off, n, "R5 random read");
            else    check(mem_mismatch() == 0, "R4 random write", mem_mismatch(), 0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule